// File: doc/BRIEF.md
# Auxiliary Compare PWM Timer

A single-output pulse-width modulator built around a free-running up-counter. Software programs a period value and a compare value through a small register write port. The output goes high when the counter is at zero and stays high until the counter reaches the active compare value. It is then low for the rest of the period. Both values are double-buffered. A write lands in a shadow copy, and the shadow copies move into the active registers only when the counter rolls over. A waveform therefore never mixes an old period with a new compare.

A control word holds two bits. The timing-mode bit enables the output. The run bit lets the counter advance. Software can also write the counter directly. Writing zero restarts the waveform at once, and writing another value resumes it from that count. The period register holds the desired period minus one. The compare value is the duty in counter ticks, from 0 up to the full period. The write port is a plain strobe that is accepted on every cycle, so it has no back-pressure.

Top module: `aux_pwm_timer`

## Requirements
- R1: After reset the counter reads 0, the output is low, and the active period, active compare, both shadows and the control word are all 0.
- R2: While the run bit (bit 4 of the control word) is clear, the counter holds its value. While it is set, the counter advances by one per clock.
- R3: A running counter that equals the active period value returns to 0 on the next clock.
- R4: On that rollover the period shadow and compare shadow are copied into the active registers. A shadow write at any other time leaves the active values and the current waveform unchanged.
- R5: With the timing-mode bit (bit 9) and the run bit both set, the output is high exactly while the counter is below the active compare value.
- R6: An active compare of 0 keeps the output low for the whole period. An active compare of period value + 1 keeps it high for the whole period.
- R7: While the timing-mode bit or the run bit is clear, the output is low, even if the counter is running.
- R8: A write to the counter address loads the written value on the next clock. This takes priority over both counting and rollover, and no shadow transfer happens in that cycle.
- R9: The write address selects 0 = counter, 1 = control word, 2 = period shadow, 3 = compare shadow. Control bits other than 9 and 4 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 2 | Register select (see R9) |
| wr_data | input | CNT_W (32) | Write data |
| pwm_o | output | 1 | Pulse-width modulated output |
| count_o | output | CNT_W (32) | Current counter value |

## Verification
The assertions check the counter on every cycle: holding, stepping, rollover, and priority of a direct write. They also check that the active registers change only at rollover, and that the output is low when the mode is off or the compare is zero. Other properties only show up in the scenarios. These include the duty a programmed compare produces over a whole period, a mid-period shadow write that takes effect one period later, restart from an arbitrary written count including counter overflow, and unused control bits having no effect. The bench's reference model covers all of them cycle by cycle.

// File: rtl/apwm_pkg.sv
package apwm_pkg;
  localparam int ADDR_W = 2;
  localparam int CTRL_W = 16;
  localparam int MODE_BIT = 9;
  localparam int RUN_BIT = 4;

  typedef enum logic [ADDR_W-1:0] {
    SEL_COUNT  = 2'd0,
    SEL_CTRL   = 2'd1,
    SEL_PERIOD = 2'd2,
    SEL_CMP    = 2'd3
  } apwm_sel_e;
endpackage

// File: rtl/apwm_regs.sv
module apwm_regs
  import apwm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [CNT_W-1:0]    wr_data,
  output logic                mode_on,
  output logic                run_on,
  output logic [CNT_W-1:0]    prd_shadow,
  output logic [CNT_W-1:0]    cmp_shadow,
  output logic                cnt_load,
  output logic [CNT_W-1:0]    cnt_value
);
  logic [CTRL_W-1:0] ctrl_q;
  apwm_sel_e         sel;

  assign sel = apwm_sel_e'(wr_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      prd_shadow <= '0;
      cmp_shadow <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_CTRL:   ctrl_q     <= wr_data[CTRL_W-1:0];
        SEL_PERIOD: prd_shadow <= wr_data;
        SEL_CMP:    cmp_shadow <= wr_data;
        default:    ;
      endcase
    end
  end

  assign mode_on   = ctrl_q[MODE_BIT];
  assign run_on    = ctrl_q[RUN_BIT];
  assign cnt_load  = wr_en && (sel == SEL_COUNT);
  assign cnt_value = wr_data;

  // R9
  shadow_only_on_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == SEL_PERIOD) |=> $stable(prd_shadow));
endmodule

// File: rtl/apwm_counter.sv
module apwm_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] cnt_value,
  input  logic [CNT_W-1:0] prd_shadow,
  input  logic [CNT_W-1:0] cmp_shadow,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] prd_act,
  output logic [CNT_W-1:0] cmp_act
);
  logic at_end;
  logic rollover;

  assign at_end   = (cnt == prd_act);
  assign rollover = run && !cnt_load && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      prd_act <= '0;
      cmp_act <= '0;
    end else if (cnt_load) begin
      cnt <= cnt_value;
    end else if (run) begin
      if (at_end) begin
        cnt     <= '0;
        prd_act <= prd_shadow;
        cmp_act <= cmp_shadow;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R2
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_load) |=> $stable(cnt));
  // R2
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_load && cnt != prd_act) |=> cnt == CNT_W'($past(cnt) + CNT_W'(1)));
  // R3
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_load && cnt == prd_act) |=> cnt == '0);
  // R4
  active_only_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rollover |=> ($stable(prd_act) && $stable(cmp_act)));
  // R8
  direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> cnt == $past(cnt_value));
endmodule

// File: rtl/apwm_outgen.sv
module apwm_outgen #(
  parameter int CNT_W = 32
) (
  input  logic             enable,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp_act,
  output logic             pwm
);
  always_comb begin
    pwm = enable && (cnt < cmp_act);
  end
endmodule

// File: rtl/aux_pwm_timer.sv
module aux_pwm_timer
  import apwm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic              pwm_o,
  output logic [CNT_W-1:0]  count_o
);
  logic             mode_on, run_on, cnt_load;
  logic [CNT_W-1:0] prd_shadow, cmp_shadow, cnt_value;
  logic [CNT_W-1:0] cnt, prd_act, cmp_act;

  apwm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .mode_on    (mode_on),
    .run_on     (run_on),
    .prd_shadow (prd_shadow),
    .cmp_shadow (cmp_shadow),
    .cnt_load   (cnt_load),
    .cnt_value  (cnt_value)
  );

  apwm_counter #(.CNT_W(CNT_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run_on),
    .cnt_load   (cnt_load),
    .cnt_value  (cnt_value),
    .prd_shadow (prd_shadow),
    .cmp_shadow (cmp_shadow),
    .cnt        (cnt),
    .prd_act    (prd_act),
    .cmp_act    (cmp_act)
  );

  apwm_outgen #(.CNT_W(CNT_W)) u_outgen (
    .enable  (mode_on && run_on),
    .cnt     (cnt),
    .cmp_act (cmp_act),
    .pwm     (pwm_o)
  );

  assign count_o = cnt;

  // R7
  low_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_on && run_on) |-> !pwm_o);
  // R6
  low_on_zero_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_act == '0) |-> !pwm_o);
  // R5
  high_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_on && run_on && cnt == '0 && cmp_act != '0) |-> pwm_o);
endmodule

// File: tb/test_aux_pwm_timer.sv
`timescale 1ns/1ps
module test_aux_pwm_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = '0;
  logic        pwm_o;
  logic [31:0] count_o;

  int    n_checks = 0;
  int    n_fails = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // reference model state
  logic [31:0] m_cnt, m_prd, m_cmp, m_prd_sh, m_cmp_sh;
  bit          m_mode, m_run;

  always #2.5 clk = ~clk;

  aux_pwm_timer i_aux_pwm_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_o(pwm_o), .count_o(count_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_prd = 0; m_cmp = 0; m_prd_sh = 0; m_cmp_sh = 0;
      m_mode = 0; m_run = 0;
    end else begin
      logic [31:0] n_cnt, n_prd, n_cmp;
      n_cnt = m_cnt; n_prd = m_prd; n_cmp = m_cmp;
      if (wr_en && wr_addr == 2'd0) n_cnt = wr_data;
      else if (m_run) begin
        if (m_cnt == m_prd) begin
          n_cnt = 0; n_prd = m_prd_sh; n_cmp = m_cmp_sh;
        end else n_cnt = m_cnt + 32'd1;
      end
      if (wr_en && wr_addr == 2'd1) begin m_mode = wr_data[9]; m_run = wr_data[4]; end
      if (wr_en && wr_addr == 2'd2) m_prd_sh = wr_data;
      if (wr_en && wr_addr == 2'd3) m_cmp_sh = wr_data;
      m_cnt = n_cnt; m_prd = n_prd; m_cmp = n_cmp;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit m_pwm;
      m_pwm = m_mode && m_run && (m_cnt < m_cmp);
      chk(count_o == m_cnt, {cur_req, " count"}, count_o, m_cnt);
      chk(pwm_o == m_pwm, {cur_req, " output"}, pwm_o, m_pwm);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_highs(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_o) highs++;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int highs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    cur_req = "R1";
    idle(2);
    chk(count_o == 0, "R1 count after reset", count_o, 0);
    chk(pwm_o == 1'b0, "R1 output after reset", pwm_o, 0);

    // R9: control bits other than 9 and 4 do nothing
    cur_req = "R9";
    wr(2'd2, 32'd9);
    wr(2'd3, 32'd4);
    wr(2'd1, 32'h0000_FDEF);
    idle(6);
    chk(count_o == 0, "R9 counter stays with unused bits set", count_o, 0);

    // R2 R3 R5: normal running, period 10, duty 4
    cur_req = "R2 R3 R5";
    wr(2'd1, 32'h0000_0210);
    idle(30);
    count_highs(10, highs);
    chk(highs == 4, "R5 duty over one period", highs, 4);

    // R4: mid-period shadow writes apply only at rollover
    cur_req = "R4";
    wr(2'd3, 32'd7);
    wr(2'd2, 32'd4);
    idle(25);

    // R6: zero compare and full compare
    cur_req = "R6";
    wr(2'd3, 32'd0);
    idle(12);
    count_highs(5, highs);
    chk(highs == 0, "R6 zero compare keeps low", highs, 0);
    wr(2'd2, 32'd9);
    wr(2'd3, 32'd10);
    idle(24);
    count_highs(10, highs);
    chk(highs == 10, "R6 full compare keeps high", highs, 10);

    // R7: mode off while running, then mode on but stopped
    cur_req = "R7";
    wr(2'd1, 32'h0000_0010);
    count_highs(15, highs);
    chk(highs == 0, "R7 mode off keeps low", highs, 0);
    cur_req = "R2 R7";
    wr(2'd1, 32'h0000_0200);
    idle(6);

    // R8: direct counter writes
    cur_req = "R8";
    wr(2'd1, 32'h0000_0210);
    wr(2'd3, 32'd5);
    idle(7);
    wr(2'd0, 32'd0);
    chk(count_o == 0, "R8 restart to zero", count_o, 0);
    idle(4);
    wr(2'd0, 32'd3);
    chk(count_o == 3, "R8 load of three", count_o, 3);
    idle(12);
    wr(2'd0, 32'hFFFF_FFFE);
    chk(count_o == 32'hFFFF_FFFE, "R8 load near overflow", count_o, 32'hFFFF_FFFE);
    idle(20);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule